// File: doc/BRIEF.md
# Escaped Extraction Word Stream Decoder

This block sits behind a CPU extraction queue that delivers frames as a plain sequence of 32-bit words. Each frame begins with a fixed-length internal header. The rest of the frame is payload, mixed with in-band status words. The status words share the data word space, and an escape word lets a payload word that looks like a status word pass through untouched. The block takes words over a valid/ready input. It captures the header, keeps the source port field from it, and rebuilds the payload as a 32-bit output stream with byte keep, last, error and a running byte length.

Each frame ends with a 4-byte check sequence, which the block removes. To do this it keeps the two most recent payload words in hand, so the output trails the input by one payload word plus the output register. A frame that is aborted or pruned, or that holds too few words, closes with a single error beat that carries no bytes. An optional byte swap is applied to each word before it is compared with the status codes. Payload is always passed on unswapped. A synchronous flush drops the frame in progress.

Top module: `esc_stream_decoder`

## Requirements
- R1: The first HDR_WORDS accepted words of each frame (default 9) are taken as header, are never emitted, and are not checked for status codes.
- R2: The header is read as one vector with word 0 most significant and bit 0 the LSB of the last header word. `src_port` shows header bits 52:46, which is bits 20:14 of header word HDR_WORDS-2, on every beat of the frame.
- R3: A status word 0x80000000+n (n = 0..3) ends the frame. The last data word held 4-n valid bytes, so after the 4 check bytes are removed the final beat is the data word before it, with keep covering the low 4-n byte lanes (lane 0 = bits 7:0). All earlier beats have keep 4'hF.
- R4: `out_len` gives the number of bytes emitted in the frame up to and including the current beat.
- R5: Status word 0x80000005 (abort) ends the frame at once. The frame closes with a beat that has last=1, err=1 and keep=0.
- R6: Status word 0x80000004 (pruned) makes the next word count as frame data whatever its value. The frame then closes with an error beat (last=1, err=1, keep=0) and no further data beats.
- R7: Status word 0x80000006 (escape) is dropped, and the word after it is taken as literal payload even if it equals a status code.
- R8: Status word 0x80000007 (not ready) is dropped and the frame stays open.
- R9: When `swap_en` is 1, a word is byte-reversed before it is compared with the status codes. Payload is emitted exactly as received.
- R10: An end-of-frame status word with fewer than two payload words in hand closes the frame with an error beat: last=1, err=1, keep=0, len=0.
- R11: `flush` drops the frame in progress and the pending output beat. The next accepted word is header word 0.
- R12: While `out_valid` is high and `out_ready` is low, the output beat holds steady and `in_ready` is low.
- R13: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous drop of the current frame |
| swap_en | input | 1 | Byte-reverse words before status code compare |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 32 | Output payload word |
| out_keep | output | 4 | Valid byte lanes, bit i for bits 8i+7:8i |
| out_last | output | 1 | Last beat of the frame |
| out_err | output | 1 | Frame discarded (abort, prune, runt) |
| out_len | output | LEN_W | Bytes emitted in the frame so far |
| src_port | output | 7 | Source port from the header |

## Verification
A header counter that is off by one word shows up at once. Either the last header word comes out as the first beat, or the first payload word goes missing, and `src_port` then takes its value from the wrong word, so the first beat of the frame reveals it. If the count of words in hand is wrong, the last beat comes out of place, and `out_len` and `out_keep` at the end-of-frame beat differ within the same frame. A parser stuck in the escape or pruned state makes the next frame's status codes read as data, so the following frame never closes or closes with the wrong error bit.

// File: rtl/esc_stream_decoder.sv
module esc_stream_decoder #(
  parameter int HDR_WORDS = 9,
  parameter int LEN_W     = 16,
  parameter int SRC_LSB   = 46,
  parameter int SRC_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             swap_en,
  input  logic             in_valid,
  input  logic [31:0]      in_data,
  output logic             in_ready,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [31:0]      out_data,
  output logic [3:0]       out_keep,
  output logic             out_last,
  output logic             out_err,
  output logic [LEN_W-1:0] out_len,
  output logic [SRC_W-1:0] src_port
);
  localparam int SRC_WORD = HDR_WORDS - 1 - SRC_LSB / 32;
  localparam int SRC_OFF  = SRC_LSB % 32;
  localparam int HC_W     = $clog2(HDR_WORDS);

  typedef enum logic [1:0] {S_HDR, S_BODY, S_ESC, S_PRUNE} st_t;

  st_t              st;
  logic [HC_W-1:0]  hcnt;
  logic [1:0]       held;
  logic [31:0]      h_old, h_new;
  logic [LEN_W-1:0] len_q;
  logic [SRC_W-1:0] src_q;

  function automatic logic [3:0] lanes(input logic [2:0] v);
    lanes = 4'((5'd1 << v) - 5'd1);
  endfunction

  wire [31:0] cmp     = swap_en ? {in_data[7:0], in_data[15:8], in_data[23:16], in_data[31:24]} : in_data;
  wire        is_code = cmp[31:3] == 29'h1000_0000;
  wire [2:0]  code    = cmp[2:0];
  wire [2:0]  vld     = 3'd4 - {1'b0, code[1:0]};

  assign in_ready = !out_valid || out_ready;
  wire take = in_valid && in_ready;

  wire in_body   = take && st == S_BODY;
  wire do_data   = (take && st == S_ESC) || (in_body && !is_code);
  wire do_eof    = in_body && is_code && !code[2];
  wire do_prune  = in_body && is_code && code == 3'd4;
  wire do_abort  = in_body && is_code && code == 3'd5;
  wire do_esc    = in_body && is_code && code == 3'd6;
  wire do_pend   = take && st == S_PRUNE;
  wire close_err = do_abort || do_pend || (do_eof && held != 2'd2);
  wire end_frame = do_eof || do_abort || do_pend;

  assign src_port = src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_HDR;
      hcnt      <= '0;
      held      <= '0;
      h_old     <= '0;
      h_new     <= '0;
      len_q     <= '0;
      src_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_keep  <= '0;
      out_last  <= 1'b0;
      out_err   <= 1'b0;
      out_len   <= '0;
    end else if (flush) begin
      st        <= S_HDR;
      hcnt      <= '0;
      held      <= '0;
      len_q     <= '0;
      out_valid <= 1'b0;
    end else begin
      if (out_valid && out_ready)
        out_valid <= 1'b0;

      if (take && st == S_HDR) begin
        if (hcnt == HC_W'(SRC_WORD))
          src_q <= in_data[SRC_OFF +: SRC_W];
        if (hcnt == HC_W'(HDR_WORDS - 1)) begin
          hcnt <= '0;
          st   <= S_BODY;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end

      if (do_data) begin
        st    <= S_BODY;
        h_old <= h_new;
        h_new <= in_data;
        if (held == 2'd2) begin
          out_valid <= 1'b1;
          out_data  <= h_old;
          out_keep  <= 4'hF;
          out_last  <= 1'b0;
          out_err   <= 1'b0;
          out_len   <= len_q + LEN_W'(4);
          len_q     <= len_q + LEN_W'(4);
        end else begin
          held <= held + 1'b1;
        end
      end

      if (do_esc)
        st <= S_ESC;
      if (do_prune)
        st <= S_PRUNE;

      if (do_eof && held == 2'd2) begin
        out_valid <= 1'b1;
        out_data  <= h_old;
        out_keep  <= lanes(vld);
        out_last  <= 1'b1;
        out_err   <= 1'b0;
        out_len   <= len_q + LEN_W'(vld);
      end

      if (close_err) begin
        out_valid <= 1'b1;
        out_data  <= '0;
        out_keep  <= 4'h0;
        out_last  <= 1'b1;
        out_err   <= 1'b1;
        out_len   <= len_q;
      end

      if (end_frame) begin
        st    <= S_HDR;
        hcnt  <= '0;
        held  <= '0;
        len_q <= '0;
      end
    end
  end
endmodule

// File: rtl/esc_stream_decoder_chk.sv
module esc_stream_decoder_chk #(
  parameter int LEN_W = 16,
  parameter int SRC_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             swap_en,
  input logic             in_valid,
  input logic [31:0]      in_data,
  input logic             in_ready,
  input logic             out_ready,
  input logic             out_valid,
  input logic [31:0]      out_data,
  input logic [3:0]       out_keep,
  input logic             out_last,
  input logic             out_err,
  input logic [LEN_W-1:0] out_len,
  input logic [SRC_W-1:0] src_port
);
  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !flush |=> out_valid && $stable(out_data) && $stable(out_keep) && $stable(out_last) && $stable(out_len)); // R12
  AST_STALL_IN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R12
  AST_ERR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_last && out_keep == 4'h0); // R5
  AST_MID_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> out_keep == 4'hF && out_len[1:0] == 2'b00); // R3
  AST_LAST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last && !out_err |-> out_keep inside {4'h1, 4'h3, 4'h7, 4'hF}); // R3
  AST_FLUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid); // R11
endmodule

bind esc_stream_decoder esc_stream_decoder_chk #(.LEN_W(LEN_W), .SRC_W(SRC_W)) chk_i (.*);

// File: tb/esc_stream_decoder_tb_top.sv
module esc_stream_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 16;

  logic clk = 0, rst_n = 0, flush = 0, swap_en = 0, in_valid = 0, out_ready = 1;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_last, out_err;
  logic [31:0] out_data;
  logic [3:0] out_keep;
  logic [LEN_W-1:0] out_len;
  logic [6:0] src_port;

  always #(CLK_PERIOD/2) clk = ~clk;

  esc_stream_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .swap_en(swap_en),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_keep(out_keep), .out_last(out_last), .out_err(out_err),
    .out_len(out_len), .src_port(src_port)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;
  int cap_n = 0;
  logic [31:0] cap_d [64];
  logic [3:0]  cap_k [64];
  logic        cap_l [64];
  logic        cap_e [64];
  logic [LEN_W-1:0] cap_len [64];
  logic [6:0]  cap_s [64];

  always @(negedge clk) if (out_valid && out_ready && cap_n < 64) begin
    cap_d[cap_n] = out_data; cap_k[cap_n] = out_keep; cap_l[cap_n] = out_last;
    cap_e[cap_n] = out_err; cap_len[cap_n] = out_len; cap_s[cap_n] = src_port;
    cap_n = cap_n + 1;
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] d);
    @(negedge clk); in_valid = 1; in_data = d; #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1; in_valid = 0;
  endtask

  task automatic send_hdr(input logic [6:0] src, input logic poison);
    for (int i = 0; i < 9; i++) begin
      if (i == 7) send({11'h5A5, src, 14'h2AAA});
      else if (poison && i == 0) send(32'h8000_0005);
      else if (poison && i == 3) send(32'h8000_0000);
      else send(32'h0F00_0000 + i);
    end
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  task automatic beat(input int i, input logic [31:0] d, input logic [3:0] k,
                      input logic l, input logic e, input int len, input string tag);
    if (i >= cap_n) begin
      chk(0, {tag, " missing beat"}, cap_n, i + 1);
    end else begin
      chk(cap_d[i] == d && cap_k[i] == k && cap_l[i] == l && cap_e[i] == e && cap_len[i] == LEN_W'(len),
          tag, {cap_d[i], 8'(cap_k[i]), 4'(cap_l[i]), 4'(cap_e[i]), 16'(cap_len[i])},
          {d, 8'(k), 4'(l), 4'(e), 16'(len)});
    end
  endtask

  task automatic body4(input logic [31:0] endw);
    send(32'h1111_1111); send(32'h2222_2222); send(32'h3333_3333); send(32'h4444_4444);
    send(endw);
  endtask

  task automatic t_reset();
    chk(!out_valid && in_ready, "R13 reset state", {out_valid, in_ready}, 2'b01);
  endtask

  task automatic t_basic();
    cap_n = 0; send_hdr(7'h55, 0); body4(32'h8000_0000); drain();
    chk(cap_n == 3, "R3 beat count", cap_n, 3);
    beat(0, 32'h1111_1111, 4'hF, 0, 0, 4, "R1 first beat is payload");
    beat(1, 32'h2222_2222, 4'hF, 0, 0, 8, "R4 mid len");
    beat(2, 32'h3333_3333, 4'hF, 1, 0, 12, "R3 last n=0");
    chk(cap_s[0] == 7'h55 && cap_s[2] == 7'h55, "R2 src_port", cap_s[0], 7'h55);
  endtask

  task automatic t_eof_n();
    cap_n = 0; send_hdr(7'h01, 0); body4(32'h8000_0003); drain();
    chk(cap_n == 3, "R3 count n=3", cap_n, 3);
    beat(2, 32'h3333_3333, 4'h1, 1, 0, 9, "R3 last n=3");
    chk(cap_s[0] == 7'h01, "R2 src_port 2", cap_s[0], 7'h01);
    cap_n = 0; send_hdr(7'h7F, 0); body4(32'h8000_0001); drain();
    beat(2, 32'h3333_3333, 4'h7, 1, 0, 11, "R4 len n=1");
    chk(cap_s[2] == 7'h7F, "R2 src_port 3", cap_s[2], 7'h7F);
  endtask

  task automatic t_swap();
    cap_n = 0; swap_en = 1; send_hdr(7'h10, 0);
    send(32'hA000_0001); send(32'h8000_0000); send(32'hB000_0002); send(32'hC000_0003);
    send(32'h0300_0080); drain(); swap_en = 0;
    chk(cap_n == 3, "R9 swap count", cap_n, 3);
    beat(1, 32'h8000_0000, 4'hF, 0, 0, 8, "R9 raw code word is data");
    beat(2, 32'hB000_0002, 4'h1, 1, 0, 9, "R9 swapped end code");
  endtask

  task automatic t_escape();
    cap_n = 0; send_hdr(7'h20, 0);
    send(32'hAAAA_0001); send(32'h8000_0006); send(32'h8000_0005);
    send(32'hAAAA_0002); send(32'hAAAA_0003); send(32'h8000_0000); drain();
    chk(cap_n == 3, "R7 escape count", cap_n, 3);
    beat(1, 32'h8000_0005, 4'hF, 0, 0, 8, "R7 escaped literal");
    beat(2, 32'hAAAA_0002, 4'hF, 1, 0, 12, "R7 end after escape");
  endtask

  task automatic t_notready();
    cap_n = 0; send_hdr(7'h21, 0);
    send(32'h1111_1111); send(32'h8000_0007); send(32'h2222_2222); send(32'h8000_0007);
    send(32'h3333_3333); send(32'h4444_4444); send(32'h8000_0000); drain();
    chk(cap_n == 3, "R8 not-ready count", cap_n, 3);
    beat(1, 32'h2222_2222, 4'hF, 0, 0, 8, "R8 not-ready dropped");
    beat(2, 32'h3333_3333, 4'hF, 1, 0, 12, "R8 frame stays open");
  endtask

  task automatic t_abort();
    cap_n = 0; send_hdr(7'h22, 0);
    send(32'h1111_1111); send(32'h2222_2222); send(32'h3333_3333); send(32'h8000_0005); drain();
    chk(cap_n == 2, "R5 abort count", cap_n, 2);
    beat(1, 32'h0, 4'h0, 1, 1, 4, "R5 abort beat");
  endtask

  task automatic t_prune();
    cap_n = 0; send_hdr(7'h23, 0);
    send(32'h1111_1111); send(32'h2222_2222); send(32'h8000_0004); send(32'h8000_0000); drain();
    chk(cap_n == 1, "R6 prune count", cap_n, 1);
    beat(0, 32'h0, 4'h0, 1, 1, 0, "R6 prune beat");
  endtask

  task automatic t_runt();
    cap_n = 0; send_hdr(7'h24, 0); send(32'h1111_1111); send(32'h8000_0000); drain();
    chk(cap_n == 1, "R10 runt count", cap_n, 1);
    beat(0, 32'h0, 4'h0, 1, 1, 0, "R10 runt beat");
  endtask

  task automatic t_hdr_codes();
    cap_n = 0; send_hdr(7'h33, 1); body4(32'h8000_0000); drain();
    chk(cap_n == 3, "R1 codes in header ignored", cap_n, 3);
    beat(2, 32'h3333_3333, 4'hF, 1, 0, 12, "R1 frame after coded header");
  endtask

  task automatic t_flush();
    send_hdr(7'h40, 0); send(32'h1111_1111); send(32'h2222_2222); send(32'h3333_3333);
    @(negedge clk); flush = 1; @(negedge clk); flush = 0;
    chk(!out_valid, "R11 flush clears output", out_valid, 0);
    cap_n = 0; send_hdr(7'h12, 0);
    send(32'h5555_0001); send(32'h5555_0002); send(32'h5555_0003); send(32'h5555_0004);
    send(32'h8000_0000); drain();
    chk(cap_n == 3, "R11 frame after flush", cap_n, 3);
    beat(0, 32'h5555_0001, 4'hF, 0, 0, 4, "R11 restart at header");
    chk(cap_s[0] == 7'h12, "R11 src after flush", cap_s[0], 7'h12);
  endtask

  task automatic t_backpressure();
    cap_n = 0;
    @(posedge clk); #1; out_ready = 0;
    send_hdr(7'h44, 0); send(32'h1111_1111); send(32'h2222_2222); send(32'h3333_3333);
    repeat (5) @(negedge clk);
    chk(out_valid && out_data == 32'h1111_1111, "R12 beat held", out_data, 32'h1111_1111);
    chk(!in_ready, "R12 in_ready low", in_ready, 0);
    @(posedge clk); #1; out_ready = 1;
    send(32'h4444_4444); send(32'h8000_0000); drain();
    chk(cap_n == 3, "R12 no beat lost", cap_n, 3);
    beat(0, 32'h1111_1111, 4'hF, 0, 0, 4, "R12 first beat");
    beat(2, 32'h3333_3333, 4'hF, 1, 0, 12, "R12 last beat");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_basic();
    t_eof_n();
    t_swap();
    t_escape();
    t_notready();
    t_abort();
    t_prune();
    t_runt();
    t_hdr_codes();
    t_flush();
    t_backpressure();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule